// File: doc/BRIEF.md
# Two-Thread SMT Issue Prioritizer

This block decides how the two issue slots of a two-way in-order multithreaded core are split between its hardware threads in each cycle. Both threads run parts of one parallel program and report each pass through a common synchronisation marker, a meeting point, as a single-cycle pulse tagged with the thread ID. The block keeps a signed progress difference between the threads and remembers which thread is ahead. The thread that is behind is treated as critical.

While the difference is positive, a critical thread that has two ready instructions takes both slots. In every other case the block applies the fair default. When both threads have work, each issues one instruction. When only one thread has work, that thread may use both slots. Each cycle, both threads present their ready-instruction counts, and the block returns a grant count for each thread from those counts and its registered state.

Top module: `smt_issue_prio`

## Requirements
- R1: After reset the progress difference is zero and the fast-thread ID is 0, so the threads start balanced: with both threads showing 2 ready, each is granted 1.
- R2: Without prioritization, if both threads have at least one ready instruction, each thread is granted exactly 1.
- R3: Without prioritization, if only one thread has ready instructions, that thread is granted its ready count (at most 2) and the other is granted 0. If neither thread is ready, both grants are 0.
- R4: A meeting-point pulse (mp_valid=1, mp_tid 0 or 1) that arrives while the difference is zero loads the reporting thread's ID as the fast thread and raises the difference to 1 at the next clock edge.
- R5: A pulse from the fast thread raises the difference by one. A pulse from the other thread lowers it by one. With no pulse, the difference and the fast-thread ID hold.
- R6: Prioritization applies only while the difference is greater than zero. The critical thread is the one whose ID is not the fast-thread ID. If the critical thread then has 2 ready, it is granted 2 and the other thread is granted 0, whatever the other thread has ready.
- R7: While prioritization applies and the critical thread has only 1 ready, the critical thread is granted 1 and the other thread may take the second slot (granted 1 if it has work). If the critical thread has 0 ready, the other thread is granted as under R3.
- R8: The difference is an 8-bit signed value that saturates at +127 and at -128 and does not wrap.
- R9: A ready count of 3 (2-bit unsigned encoding) is treated as 2.
- R10: In every cycle the two grants sum to at most 2, and neither grant exceeds its thread's clamped ready count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| mp_valid | input | 1 | Meeting-point pulse, one per report |
| mp_tid | input | 1 | Thread ID of the reporting thread |
| rdy_cnt0 | input | 2 | Ready instructions of thread 0 |
| rdy_cnt1 | input | 2 | Ready instructions of thread 1 |
| grant0 | output | 2 | Instructions thread 0 may issue this cycle |
| grant1 | output | 2 | Instructions thread 1 may issue this cycle |

## Verification
Each state of the progress difference is checked with four kinds of ready pattern: both threads full, the critical thread with one instruction, the critical thread idle, and neither thread ready. Together these separate the priority override from the fair split and from the single-thread fallback. Pulse sequences run in both orders: first thread 0 ahead, then thread 1 ahead after the threads rebalance. This shows that the fast ID is reloaded only at zero. A run of 130 pulses from one thread, followed by 127 from the other, shows the upper bound saturating. Priority must still apply after 126 of the later pulses and must end exactly at the 127th. A ready count of 3 is applied in both the fair state and the prioritized state.

// File: rtl/smt_prio_pkg.sv
package smt_prio_pkg;
  localparam int RDY_W   = 2;
  localparam int SLOTS   = 2;
  localparam int DELTA_W = 8;
  typedef logic [RDY_W-1:0] cnt_t;
endpackage

// File: rtl/smt_prio_tracker.sv
module smt_prio_tracker #(
  parameter int DW = smt_prio_pkg::DELTA_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mp_valid,
  input  logic mp_tid,
  output logic prio_active,
  output logic crit_tid
);
  localparam logic signed [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] D_ONE = {{(DW-1){1'b0}}, 1'b1};

  logic signed [DW-1:0] delta_q, delta_d;
  logic fast_q, fast_d, lead_tid, upd_en;

  assign upd_en = mp_valid;

  always_comb begin
    delta_d  = delta_q;
    fast_d   = fast_q;
    lead_tid = fast_q;
    if (mp_valid) begin
      lead_tid = (delta_q == '0) ? mp_tid : fast_q;
      fast_d   = lead_tid;
      if (mp_tid == lead_tid) begin
        if (delta_q != D_MAX) delta_d = delta_q + D_ONE;
      end else begin
        if (delta_q != D_MIN) delta_d = delta_q - D_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
      fast_q  <= 1'b0;
    end else if (upd_en) begin
      delta_q <= delta_d;
      fast_q  <= fast_d;
    end
  end

  assign prio_active = !delta_q[DW-1] && (delta_q != '0);
  assign crit_tid    = ~fast_q;

  // R4: zero difference reloads the fast ID from the reporter
  assert_load_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_valid && delta_q == '0) |=> (fast_q == $past(mp_tid) && delta_q == D_ONE));
  // R5: a report from the fast thread counts up by one
  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_valid && delta_q != '0 && delta_q != D_MAX && mp_tid == fast_q)
    |=> (delta_q == $past(delta_q) + D_ONE));
  // R5: no pulse leaves the state untouched
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mp_valid |=> ($stable(delta_q) && $stable(fast_q)));
  // R8: the upper limit holds
  assert_sat_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_valid && delta_q == D_MAX && mp_tid == fast_q) |=> (delta_q == D_MAX));
endmodule

// File: rtl/smt_slot_alloc.sv
module smt_slot_alloc
  import smt_prio_pkg::*;
(
  input  cnt_t rdy0,
  input  cnt_t rdy1,
  input  logic prio_active,
  input  logic crit_tid,
  output cnt_t grant0,
  output cnt_t grant1
);
  localparam cnt_t FULL = cnt_t'(SLOTS);

  cnt_t clamp [2];
  cnt_t gnt [2];

  // R9: counts above the issue width are clipped
  assign clamp[0] = (rdy0 > FULL) ? FULL : rdy0;
  assign clamp[1] = (rdy1 > FULL) ? FULL : rdy1;

  always_comb begin
    gnt[0] = clamp[0];
    gnt[1] = clamp[1];
    if (prio_active && clamp[crit_tid] == FULL) begin
      gnt[crit_tid]  = FULL;
      gnt[~crit_tid] = '0;
    end else if (clamp[0] != '0 && clamp[1] != '0) begin
      gnt[0] = cnt_t'(1);
      gnt[1] = cnt_t'(1);
    end
  end

  assign grant0 = gnt[0];
  assign grant1 = gnt[1];
endmodule

// File: rtl/smt_issue_prio.sv
module smt_issue_prio
  import smt_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mp_valid,
  input  logic       mp_tid,
  input  logic [1:0] rdy_cnt0,
  input  logic [1:0] rdy_cnt1,
  output logic [1:0] grant0,
  output logic [1:0] grant1
);
  logic prio_active, crit_tid;

  smt_prio_tracker #(.DW(DELTA_W)) u_track (
    .clk(clk), .rst_n(rst_n), .mp_valid(mp_valid), .mp_tid(mp_tid),
    .prio_active(prio_active), .crit_tid(crit_tid)
  );

  smt_slot_alloc u_alloc (
    .rdy0(rdy_cnt0), .rdy1(rdy_cnt1), .prio_active(prio_active),
    .crit_tid(crit_tid), .grant0(grant0), .grant1(grant1)
  );

  // R10: never more than the issue width
  assert_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, grant0} + {1'b0, grant1}) <= 3'd2);
  // R10: no thread gets more than it has
  assert_le_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant0 <= rdy_cnt0) && (grant1 <= rdy_cnt1));
  // R6: full critical thread takes both slots
  assert_prio_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_active && !crit_tid && rdy_cnt0[1]) |-> (grant0 == 2'd2 && grant1 == 2'd0));
  // R2: balanced and both busy splits evenly
  assert_fair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio_active && rdy_cnt0 != 2'd0 && rdy_cnt1 != 2'd0) |-> (grant0 == 2'd1 && grant1 == 2'd1));
endmodule

// File: tb/smt_issue_prio_bench.sv
module smt_issue_prio_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mp_valid = 1'b0, mp_tid = 1'b0;
  logic [1:0] rdy_cnt0 = 2'd0, rdy_cnt1 = 2'd0;
  logic [1:0] grant0, grant1;

  smt_issue_prio u_smt_issue_prio (
    .clk(clk), .rst_n(rst_n), .mp_valid(mp_valid), .mp_tid(mp_tid),
    .rdy_cnt0(rdy_cnt0), .rdy_cnt1(rdy_cnt1), .grant0(grant0), .grant1(grant1)
  );

  always #4 clk = ~clk;

  typedef struct { logic [1:0] e0; logic [1:0] e1; string tag; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  int m_delta = 0;
  logic m_fast = 1'b0;
  bit done = 0;

  function automatic logic [1:0] clip(input logic [1:0] r);
    return (r == 2'd3) ? 2'd2 : r;
  endfunction

  task automatic step(input logic mv, input logic tid,
                      input logic [1:0] r0, input logic [1:0] r1, input string tag);
    item_t it;
    logic [1:0] c0, c1, cc;
    @(negedge clk);
    mp_valid = mv; mp_tid = tid; rdy_cnt0 = r0; rdy_cnt1 = r1;
    c0 = clip(r0); c1 = clip(r1);
    cc = m_fast ? c0 : c1;
    if (m_delta > 0 && cc == 2'd2) begin
      it.e0 = m_fast ? 2'd2 : 2'd0;
      it.e1 = m_fast ? 2'd0 : 2'd2;
    end else if (c0 != 0 && c1 != 0) begin
      it.e0 = 2'd1; it.e1 = 2'd1;
    end else begin
      it.e0 = c0; it.e1 = c1;
    end
    it.tag = tag;
    sb.push_back(it);
    if (mv && rst_n) begin
      if (m_delta == 0) m_fast = tid;
      if (tid == m_fast) m_delta = (m_delta < 127) ? m_delta + 1 : 127;
      else               m_delta = (m_delta > -128) ? m_delta - 1 : -128;
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (grant0 !== it.e0 || grant1 !== it.e1) begin
        bad++;
        $display("FAIL %s: grants=%0d/%0d expected=%0d/%0d", it.tag, grant0, grant1, it.e0, it.e1);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(0, 0, 2'd2, 2'd2, "R1 reset balanced");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 2'd2, 2'd2, "R1 after reset");
    step(0, 0, 2'd2, 2'd2, "R2 both full");
    step(0, 0, 2'd1, 2'd2, "R2 mixed");
    step(0, 0, 2'd2, 2'd0, "R3 t0 only");
    step(0, 0, 2'd0, 2'd1, "R3 t1 single");
    step(0, 0, 2'd0, 2'd0, "R3 idle");
    step(0, 0, 2'd3, 2'd0, "R9 clip base");
    step(1, 0, 2'd0, 2'd0, "R4 load t0");
    step(0, 0, 2'd2, 2'd2, "R6 t1 critical");
    step(0, 0, 2'd1, 2'd2, "R6 other low");
    step(0, 0, 2'd2, 2'd3, "R9 clip prio");
    step(0, 0, 2'd2, 2'd1, "R7 crit one");
    step(0, 0, 2'd2, 2'd0, "R7 crit idle");
    step(1, 0, 2'd0, 2'd0, "R5 up");
    step(1, 1, 2'd0, 2'd0, "R5 down");
    step(0, 0, 2'd2, 2'd2, "R5 still ahead");
    step(1, 1, 2'd0, 2'd0, "R5 down to zero");
    step(0, 0, 2'd2, 2'd2, "R5 rebalanced");
    step(1, 1, 2'd0, 2'd0, "R4 load t1");
    step(0, 0, 2'd2, 2'd2, "R4 t0 critical");
    step(1, 0, 2'd0, 2'd0, "R5 slow report");
    step(0, 0, 2'd2, 2'd2, "R5 zero again");
    for (int i = 0; i < 130; i++) step(1, 0, 2'd0, 2'd0, "R8 climb");
    for (int i = 0; i < 126; i++) step(1, 1, 2'd0, 2'd0, "R8 descend");
    step(0, 0, 2'd2, 2'd2, "R8 one left");
    step(1, 1, 2'd0, 2'd0, "R8 last");
    step(0, 0, 2'd2, 2'd2, "R8 saturated count");
    step(0, 0, 2'd0, 2'd0, "R10 drain");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule